// File: doc/BRIEF.md
# APB Requester Transfer Sequencer

This block turns single read or write commands from a local user into transfers on one APB requester port. The user offers a command (direction, address, write data) with a valid flag. The block takes the command when it signals ready and stores the fields, so the user can change its inputs on the next cycle. It then runs the setup phase and the access phase on the bus.

The access phase lasts as long as the completer holds `pready` low. In the first access cycle where `pready` is high, the block ends the transfer. For a read it keeps the returned data, and for every transfer it reports the completer error flag. It tells the user the command is finished with a one-cycle pulse on the next cycle.

When the user already has another command waiting in the completing cycle, the next setup phase starts straight away with `psel` still high. Otherwise the bus goes idle. Address and direction keep their last values while the bus is idle.

Top module: `apb_xfer_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the block returns to idle. After that edge `psel`, `penable` and `done` are 0, `req_ready` is 1, and `paddr`, `pwrite`, `pwdata`, `rd_data` and `err` are 0.
- R2: A command is accepted when `req_valid` and `req_ready` are both high at a clock edge. In the following cycle the bus is in setup: `psel`=1 and `penable`=0. `paddr` and `pwdata` equal the accepted fields, and `pwrite` is 1 for a write and 0 for a read.
- R3: The cycle after a setup cycle is always an access cycle, with `psel`=1 and `penable`=1.
- R4: During an access cycle in which `pready` is low, the next cycle keeps `psel`, `penable`, `paddr`, `pwrite` and `pwdata` unchanged, and `done` stays 0.
- R5: The transfer ends at the first access-cycle edge with `pready` high. In the next cycle `penable` is 0 and `done` is 1, and `done` is 1 for that single cycle only.
- R6: When a read ends, `rd_data` takes the `prdata` value present with `pready` high. When a write ends, `rd_data` keeps its previous value.
- R7: When a transfer ends, `err` takes the `pslverr` value present with `pready` high, and holds it until the next transfer ends. `pslverr` in cycles where `pready` is low has no effect.
- R8: If no command is accepted in the completing cycle, `psel` is 0 in the next cycle. `paddr` and `pwrite` then keep their last values until a new command is accepted.
- R9: If `req_valid` is high in the completing cycle, that command is accepted. The next cycle is its setup cycle, with `psel` still 1.
- R10: `req_ready` is 1 only while idle or in an access cycle with `pready` high. Changing the command inputs after acceptance has no effect on the bus outputs of the transfer under way.
- R11: Driving `rst_n` low during a transfer abandons it. `psel` and `penable` are 0 after that edge and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | User offers a command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Command address |
| req_wdata | input | DATA_W | Command write data |
| req_ready | output | 1 | Block can accept a command this cycle |
| done | output | 1 | One-cycle pulse: a transfer finished |
| rd_data | output | DATA_W | Data from the last finished read |
| err | output | 1 | Completer error flag of the last finished transfer |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable, high in access cycles |
| paddr | output | ADDR_W | APB address |
| pwrite | output | 1 | APB direction |
| pwdata | output | DATA_W | APB write data |
| pready | input | 1 | APB completer ready |
| prdata | input | DATA_W | APB read data |
| pslverr | input | 1 | APB completer error |

## Verification
A wrong phase register shows on `psel`/`penable` in the very next cycle. Examples are a setup cycle that repeats, an access phase that ends without `pready`, or an idle cycle slipped into a chained transfer. A stale or reloaded command register shows as a moved `paddr`, `pwrite` or `pwdata`, either in a wait state or in the idle cycle after completion. A fault in response capture shows in the cycle after completion as a wrong `rd_data` or `err`, or as a `done` pulse that is missing or lasts two cycles. The bench compares all of these in that cycle, across random wait lengths, error flags and chained commands.

// File: rtl/apb_seq_pkg.sv
// Package: shared phase encoding for the APB transfer sequencer.
// Assumes: three phases are enough; no burst or pipelined phase exists.
package apb_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_t;
endpackage

// File: rtl/apb_seq_phase.sv
// Module: phase controller. Walks idle -> setup -> access and back,
// and loops access -> setup when a command is waiting at completion.
// Assumes: pready is only meaningful in access cycles.
module apb_seq_phase
    import apb_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   pready,
    output logic   req_ready,
    output logic   accept,
    output logic   complete,
    output logic   sel,
    output logic   enable
);
    phase_t phase_q;
    phase_t phase_d;

    // Decode handshake and completion from the current phase.
    always_comb begin
        complete  = (phase_q == PH_ACCESS) && pready;
        req_ready = (phase_q == PH_IDLE) || complete;
        accept    = req_valid && req_ready;
        sel       = (phase_q != PH_IDLE);
        enable    = (phase_q == PH_ACCESS);
    end

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   phase_d = accept ? PH_SETUP : PH_IDLE;
            PH_SETUP:  phase_d = PH_ACCESS;
            PH_ACCESS: begin
                if (pready) begin
                    phase_d = accept ? PH_SETUP : PH_IDLE;
                end
            end
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end
endmodule

// File: rtl/apb_seq_cmd_reg.sv
// Module: command register. Captures direction, address and write data
// on acceptance and holds them, which keeps the bus fields frozen through
// wait states and leaves address and direction parked while idle.
// Assumes: load is asserted only when the bus may take a new setup phase.
module apb_seq_cmd_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              out_write,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata
);
    // Field capture on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_write <= 1'b0;
            out_addr  <= '0;
            out_wdata <= '0;
        end else if (load) begin
            out_write <= in_write;
            out_addr  <= in_addr;
            out_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/apb_seq_resp.sv
// Module: response capture. Registers read data and the error flag at
// completion and emits a one-cycle done pulse in the following cycle.
// Assumes: complete is high for exactly one cycle per transfer.
module apb_seq_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              complete,
    input  logic              is_write,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              err
);
    // Done pulse follows the completing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= complete;
        end
    end

    // Error flag refreshed at every completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (complete) begin
            err <= bus_err;
        end
    end

    // Read data kept only from finished reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (complete && !is_write) begin
            rd_data <= bus_rdata;
        end
    end
endmodule

// File: rtl/apb_xfer_seq.sv
// Module: APB requester transfer sequencer (top). Accepts one command at a
// time, runs setup and access phases, waits on pready, returns the result.
// Assumes: a single completer; the user holds req_valid until accepted.
module apb_xfer_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              err,
    output logic              psel,
    output logic              penable,
    output logic [ADDR_W-1:0] paddr,
    output logic              pwrite,
    output logic [DATA_W-1:0] pwdata,
    input  logic              pready,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pslverr
);
    logic accept;
    logic complete;

    apb_seq_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .pready    (pready),
        .req_ready (req_ready),
        .accept    (accept),
        .complete  (complete),
        .sel       (psel),
        .enable    (penable)
    );

    apb_seq_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .in_write  (req_write),
        .in_addr   (req_addr),
        .in_wdata  (req_wdata),
        .out_write (pwrite),
        .out_addr  (paddr),
        .out_wdata (pwdata)
    );

    apb_seq_resp #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .complete  (complete),
        .is_write  (pwrite),
        .bus_rdata (prdata),
        .bus_err   (pslverr),
        .done      (done),
        .rd_data   (rd_data),
        .err       (err)
    );
endmodule

// File: rtl/apb_xfer_seq_chk.sv
// Module: protocol checker for the transfer sequencer, bound to the top.
// Assumes: the same clock and synchronous reset as the sequencer.
module apb_xfer_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              done,
    input logic              err,
    input logic              psel,
    input logic              penable,
    input logic [ADDR_W-1:0] paddr,
    input logic              pwrite,
    input logic [DATA_W-1:0] pwdata,
    input logic              pready,
    input logic              pslverr
);
    AST_ACCEPT_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> psel && !penable && paddr == $past(req_addr) && pwrite == $past(req_write)); // R2
    AST_SETUP_TO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !penable |=> psel && penable); // R3
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && !pready |=> psel && penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata) && !done); // R4
    AST_END_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        penable && pready |=> !penable && done); // R5
    AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(penable && pready)); // R5
    AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        penable && pready |=> err == $past(pslverr)); // R7
    AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !psel && !req_valid |=> $stable(paddr) && $stable(pwrite)); // R8
    AST_READY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !psel || (penable && pready)); // R10
endmodule

bind apb_xfer_seq apb_xfer_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .psel      (psel),
    .penable   (penable),
    .paddr     (paddr),
    .pwrite    (pwrite),
    .pwdata    (pwdata),
    .pready    (pready),
    .pslverr   (pslverr)
);

// File: tb/apb_xfer_seq_tb.sv
`timescale 1ns/1ps
module apb_xfer_seq_tb;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          done;
    logic [DW-1:0] rd_data;
    logic          err;
    logic          psel;
    logic          penable;
    logic [AW-1:0] paddr;
    logic          pwrite;
    logic [DW-1:0] pwdata;
    logic          pready = 1'b0;
    logic [DW-1:0] prdata = '0;
    logic          pslverr = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [DW-1:0] exp_rd = '0;
    logic          exp_err = 1'b0;
    bit            pend = 1'b0;

    always #5 clk = ~clk;

    apb_xfer_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .err(err), .psel(psel), .penable(penable),
        .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata), .pready(pready),
        .prdata(prdata), .pslverr(pslverr)
    );

    // Completer read-data model: value returned for an address.
    function automatic logic [DW-1:0] rd_pattern(input logic [AW-1:0] a);
        return {a, ~a} ^ 32'h3C5A_96E1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic present(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        #1;
    endtask

    task automatic scramble();
        req_valid = 1'b0;
        req_write = 1'($urandom);
        req_addr  = AW'($urandom);
        req_wdata = $urandom;
    endtask

    // One full transfer; optionally chains the next command at completion.
    task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int waits, input logic perr, input bit chain,
                        input logic nw, input logic [AW-1:0] na, input logic [DW-1:0] nd);
        if (!pend) begin
            present(w, a, d);
            chk(req_ready == 1'b1, "R10 ready when idle", 64'(req_ready), 64'd1);
            step();
            chk(done == 1'b0, "R5 done single cycle", 64'(done), 64'd0);
        end
        pend = 1'b0;
        scramble();
        // setup cycle
        chk(psel && !penable, "R2 setup phase", {62'd0, psel, penable}, 64'b10);
        chk(paddr == a && pwrite == w && pwdata == d, "R2 setup fields",
            {15'd0, pwrite, paddr, pwdata}, {15'd0, w, a, d});
        step();
        for (int i = 0; i <= waits; i++) begin
            chk(psel && penable, "R3 access phase", {62'd0, psel, penable}, 64'b11);
            chk(paddr == a && pwrite == w && pwdata == d, "R4 frozen fields",
                {15'd0, pwrite, paddr, pwdata}, {15'd0, w, a, d});
            chk(done == 1'b0, "R4 no done while waiting", 64'(done), 64'd0);
            pready  = (i == waits);
            prdata  = (i == waits) ? rd_pattern(a) : $urandom;
            pslverr = (i == waits) ? perr : 1'($urandom);
            if (i == waits && chain) begin
                present(nw, na, nd);
                pend = 1'b1;
            end else begin
                scramble();
                #1;
            end
            chk(req_ready == (i == waits), "R10 ready window", 64'(req_ready), 64'(i == waits));
            step();
        end
        pready = 1'b0;
        pslverr = 1'b0;
        if (!w) exp_rd = rd_pattern(a);
        exp_err = perr;
        chk(done == 1'b1 && !penable, "R5 end of transfer", {62'd0, done, penable}, 64'b10);
        chk(rd_data == exp_rd, w ? "R6 write keeps rd_data" : "R6 read capture", 64'(rd_data), 64'(exp_rd));
        chk(err == exp_err, "R7 error capture", 64'(err), 64'(exp_err));
        if (chain) begin
            chk(psel == 1'b1 && paddr == na, "R9 back-to-back setup",
                {47'd0, psel, paddr}, {47'd1, na});
        end else begin
            chk(psel == 1'b0, "R8 select released", 64'(psel), 64'd0);
            chk(paddr == a && pwrite == w, "R8 parked fields",
                {47'd0, pwrite, paddr}, {47'd0, w, a});
        end
    endtask

    initial begin
        logic          cw;
        logic [AW-1:0] ca;
        logic [DW-1:0] cd;
        void'($urandom(32'h1234_ABCD));
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1 reset state
        chk(!psel && !penable && !done && req_ready, "R1 reset controls",
            {60'd0, psel, penable, done, req_ready}, 64'd1);
        chk(paddr == 0 && pwrite == 0 && pwdata == 0 && rd_data == 0 && err == 0, "R1 reset data",
            {15'd0, pwrite, paddr, pwdata}, 64'd0);
        rst_n = 1'b1;
        step();

        // Directed: zero-wait write, zero-wait read, long wait with error
        xfer(1'b1, 16'h0010, 32'hDEAD_BEEF, 0, 1'b0, 1'b0, 1'b0, '0, '0);
        scramble();
        step();
        chk(psel == 0 && paddr == 16'h0010 && pwrite == 1'b1, "R8 idle hold",
            {47'd0, psel, pwrite, paddr}, {47'd0, 1'b0, 1'b1, 16'h0010});
        xfer(1'b0, 16'h0020, '0, 0, 1'b0, 1'b0, 1'b0, '0, '0);
        xfer(1'b0, 16'hFFFF, '0, 5, 1'b1, 1'b0, 1'b0, '0, '0);
        // R7 error refreshed to 0, R6 write keeps read data
        xfer(1'b1, 16'h0000, 32'h0123_4567, 2, 1'b0, 1'b1, 1'b0, 16'h0AB0, '0);
        xfer(1'b0, 16'h0AB0, '0, 1, 1'b1, 1'b0, 1'b0, '0, '0);

        // R11 reset in the middle of a transfer
        present(1'b1, 16'h5555, 32'h1111_2222);
        step();
        scramble();
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk(!psel && !penable && req_ready, "R11 abandon on reset",
            {61'd0, psel, penable, req_ready}, 64'd1);
        chk(paddr == 0 && err == 0 && rd_data == 0, "R1 reset clears fields",
            {15'd0, err, paddr, rd_data}, 64'd0);
        step();
        chk(done == 1'b0, "R11 no done after reset", 64'(done), 64'd0);
        exp_rd = '0;
        exp_err = 1'b0;

        // Random stream with chaining
        cw = 1'($urandom);
        ca = AW'($urandom);
        cd = $urandom;
        for (int k = 0; k < 60; k++) begin
            logic          nw;
            logic [AW-1:0] na;
            logic [DW-1:0] nd;
            bit            ch;
            nw = 1'($urandom);
            na = AW'($urandom);
            nd = $urandom;
            ch = (k != 59) && ($urandom_range(0, 2) == 0);
            xfer(cw, ca, cd, $urandom_range(0, 4), ($urandom_range(0, 3) == 0), ch, nw, na, nd);
            if (!ch && $urandom_range(0, 1) == 1) begin
                scramble();
                step();
            end
            cw = nw;
            ca = na;
            cd = nd;
        end
        req_valid = 1'b0;
        step();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule